// File: doc/BRIEF.md
# Frame-Synchronized Shadow Register Bank

This block holds the control registers of a video timing engine. Software writes arrive over a plain address/data write strobe, usually from a 3-wire serial receiver. Ordinary writes go into a shadow copy. The shadow copy moves into the active copy only on a falling edge of the combined vertical/horizontal sync, so that a frame never sees a half-updated register set.

A hold bit freezes these commits while software rewrites a group of registers. The hold bit takes effect at once, and so does the software reset. Releasing the hold lets the next sync falling edge apply everything that is pending. Two control bits share the commit path with the ordinary registers. One is an output-enable that gates the downstream clocks. The other is an active-low timing-core reset. The core only runs after that bit has been driven low and then high.

The block's outputs are the committed register contents, the output-enable level and a core-run flag.

Top module: `sync_shadow_regbank`

## Requirements
- R1: After power-on reset (rst_n low), every active general register holds REG_DEFAULT (0x00), out_enable is 0 and core_run is 0.
- R2: A write to a general address 0x00..NUM_REGS-1 (data bits [DATA_W-1:0]) changes the shadow copy only. The active value at active_regs[i*DATA_W +: DATA_W] does not change until a commit.
- R3: A commit happens when the AND of vd_in and hd_in, synchronized through two flip-flops, goes from 1 to 0. The active copy changes on the third rising clock edge after the combined level falls at the pins.
- R4: Writing 1 to bit 0 of address 0x14 sets the hold bit at once, and while it is set no commit takes place. Writing 0 releases the hold, and pending data is applied at the next sync falling edge, not at the release.
- R5: Bit 0 of address 0x11 is the output-enable. out_enable changes only when this bit is committed.
- R6: Bit 0 of address 0x12 is an active-low core reset. core_run becomes 1 only once a 0 and later a 1 have been committed. Writing and committing a 1 from reset alone leaves core_run at 0.
- R7: If a 0 and then a 1 are written to address 0x12 between two commits while the core runs, core_run drops to 0 for exactly one clock cycle at the commit and then returns to 1.
- R8: Writing 1 to bit 0 of address 0x10 returns, on that clock edge, the shadow and active registers, out_enable, core_run and the hold bit to their defaults. A later sync edge then applies nothing stale. The bit is a pulse and keeps no state.
- R9: Writes to unimplemented addresses (such as 0x13, 0x15, 0x20) and a write of 0 to address 0x10 change no output, either immediately or after a commit.
- R10: When one address is written several times before a commit, the last value is applied. Later commits with no new writes leave the active value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| vd_in | input | 1 | Vertical sync, asynchronous |
| hd_in | input | 1 | Horizontal sync, asynchronous |
| active_regs | output | NUM_REGS*DATA_W | Committed general registers, register i at bits [i*DATA_W +: DATA_W] |
| out_enable | output | 1 | Committed output-enable, gates clock outputs |
| core_run | output | 1 | Timing core released from reset |

## Verification
The assertions assume that sync falling edges are at least four clock cycles apart, so that a one-cycle core restart completes before the next commit. They also assume that wr_en carries at most one write per cycle. The bench holds vd_in low for five cycles and high for five or more before its next step. Writes are issued one per cycle on the falling clock edge, and the write strobe is never active in the same cycle as a detected fall.

// File: rtl/ssrb_pkg.sv
`timescale 1ns/1ps
package ssrb_pkg;
   // decoded target of one write cycle
   typedef enum logic [2:0] {
      DEC_NONE,
      DEC_GEN,
      DEC_SWRST,
      DEC_OE,
      DEC_CORE,
      DEC_HOLD
   } ssrb_dec_e;
endpackage

// File: rtl/ssrb_sync_fall.sv
`timescale 1ns/1ps
module ssrb_sync_fall #(
   parameter int STAGES      = 2,
   parameter bit COMBINE_AND = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vd,
   input  logic hd,
   output logic fall
);
   logic [STAGES-1:0] vd_q, hd_q;
   logic              comb, comb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vd_q   <= '0;
         hd_q   <= '0;
         comb_q <= 1'b0;
      end else begin
         vd_q   <= {vd_q[STAGES-2:0], vd};
         hd_q   <= {hd_q[STAGES-2:0], hd};
         comb_q <= comb;
      end
   end

   generate
      if (COMBINE_AND) begin : g_and
         assign comb = vd_q[STAGES-1] & hd_q[STAGES-1];
      end else begin : g_or
         assign comb = vd_q[STAGES-1] | hd_q[STAGES-1];
      end
   endgenerate

   assign fall = comb_q & ~comb;
endmodule

// File: rtl/ssrb_shadow_cell.sv
`timescale 1ns/1ps
module ssrb_shadow_cell #(
   parameter int           W    = 8,
   parameter logic [W-1:0] DFLT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         commit,
   output logic [W-1:0] q
);
   logic [W-1:0] shadow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= DFLT;
         q      <= DFLT;
      end else if (clr) begin
         shadow <= DFLT;
         q      <= DFLT;
      end else begin
         if (commit) q <= shadow;     // old shadow; a same-cycle load stays pending
         if (load)   shadow <= din;
      end
   end
endmodule

// File: rtl/ssrb_core_ctrl.sv
`timescale 1ns/1ps
module ssrb_core_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic wr,
   input  logic wbit,
   input  logic commit,
   output logic run
);
   logic shadow, low_seen, armed, pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= 1'b0; low_seen <= 1'b0; armed <= 1'b0; pend <= 1'b0; run <= 1'b0;
      end else if (clr) begin
         shadow <= 1'b0; low_seen <= 1'b0; armed <= 1'b0; pend <= 1'b0; run <= 1'b0;
      end else begin
         if (wr) shadow <= wbit;
         if (commit) begin
            low_seen <= wr & ~wbit;
            if (low_seen) armed <= 1'b1;
            run  <= low_seen ? 1'b0 : (shadow & armed);
            pend <= low_seen & shadow;
         end else begin
            if (wr && !wbit) low_seen <= 1'b1;
            if (pend) begin
               run  <= 1'b1;
               pend <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/sync_shadow_regbank.sv
`timescale 1ns/1ps
module sync_shadow_regbank #(
   parameter int                  DATA_W      = 8,
   parameter int                  ADDR_W      = 8,
   parameter int                  NUM_REGS    = 16,
   parameter int                  SYNC_STAGES = 2,
   parameter bit                  COMBINE_AND = 1'b1,
   parameter logic [DATA_W-1:0]   REG_DEFAULT = '0,
   parameter logic [ADDR_W-1:0]   ADDR_SWRST  = 'h10,
   parameter logic [ADDR_W-1:0]   ADDR_OE     = 'h11,
   parameter logic [ADDR_W-1:0]   ADDR_CORE   = 'h12,
   parameter logic [ADDR_W-1:0]   ADDR_HOLD   = 'h14
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic                         vd_in,
   input  logic                         hd_in,
   output logic [NUM_REGS*DATA_W-1:0]   active_regs,
   output logic                         out_enable,
   output logic                         core_run
);
   import ssrb_pkg::*;

   localparam logic [ADDR_W:0] NREG_LIM = (ADDR_W+1)'(NUM_REGS);

   generate
      if (DATA_W < 1 || ADDR_W < 2 || SYNC_STAGES < 2) begin : g_bad_width
         $error("sync_shadow_regbank: DATA_W>=1, ADDR_W>=2, SYNC_STAGES>=2 required");
      end
      if (NUM_REGS < 1 || NUM_REGS > int'(ADDR_SWRST) || NUM_REGS > int'(ADDR_OE) ||
          NUM_REGS > int'(ADDR_CORE) || NUM_REGS > int'(ADDR_HOLD)) begin : g_bad_map
         $error("sync_shadow_regbank: general registers overlap control addresses");
      end
   endgenerate

   ssrb_dec_e dec;
   logic      sync_fall, commit, hold_q, sw_clr;

   always_comb begin
      dec = DEC_NONE;
      if (wr_en) begin
         if ({1'b0, wr_addr} < NREG_LIM)  dec = DEC_GEN;
         else if (wr_addr == ADDR_SWRST)  dec = wr_data[0] ? DEC_SWRST : DEC_NONE;
         else if (wr_addr == ADDR_OE)     dec = DEC_OE;
         else if (wr_addr == ADDR_CORE)   dec = DEC_CORE;
         else if (wr_addr == ADDR_HOLD)   dec = DEC_HOLD;
      end
   end

   assign sw_clr = (dec == DEC_SWRST);

   ssrb_sync_fall #(.STAGES(SYNC_STAGES), .COMBINE_AND(COMBINE_AND)) u_sync (
      .clk(clk), .rst_n(rst_n), .vd(vd_in), .hd(hd_in), .fall(sync_fall));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              hold_q <= 1'b0;
      else if (sw_clr)         hold_q <= 1'b0;
      else if (dec == DEC_HOLD) hold_q <= wr_data[0];
   end

   assign commit = sync_fall & ~hold_q;

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
         ssrb_shadow_cell #(.W(DATA_W), .DFLT(REG_DEFAULT)) u_cell (
            .clk(clk), .rst_n(rst_n), .clr(sw_clr),
            .load((dec == DEC_GEN) && (wr_addr == IDX)),
            .din(wr_data), .commit(commit),
            .q(active_regs[i*DATA_W +: DATA_W]));
      end
   endgenerate

   ssrb_shadow_cell #(.W(1), .DFLT(1'b0)) u_oe (
      .clk(clk), .rst_n(rst_n), .clr(sw_clr), .load(dec == DEC_OE),
      .din(wr_data[0]), .commit(commit), .q(out_enable));

   ssrb_core_ctrl u_core (
      .clk(clk), .rst_n(rst_n), .clr(sw_clr), .wr(dec == DEC_CORE),
      .wbit(wr_data[0]), .commit(commit), .run(core_run));
endmodule

// File: rtl/ssrb_checker.sv
`timescale 1ns/1ps
module ssrb_checker #(
   parameter int                DATA_W      = 8,
   parameter int                ADDR_W      = 8,
   parameter int                NUM_REGS    = 16,
   parameter logic [DATA_W-1:0] REG_DEFAULT = '0,
   parameter logic [ADDR_W-1:0] ADDR_SWRST  = 'h10,
   parameter logic [ADDR_W-1:0] ADDR_HOLD   = 'h14
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_en,
   input logic [ADDR_W-1:0]          wr_addr,
   input logic [DATA_W-1:0]          wr_data,
   input logic [NUM_REGS*DATA_W-1:0] active_regs,
   input logic                       out_enable,
   input logic                       core_run,
   input logic                       fall,
   input logic                       commit
);
   localparam logic [NUM_REGS*DATA_W-1:0] ALL_DFLT = {NUM_REGS{REG_DEFAULT}};

   logic swr, hold_set;
   assign swr      = wr_en && (wr_addr == ADDR_SWRST) && wr_data[0];
   assign hold_set = wr_en && (wr_addr == ADDR_HOLD) && wr_data[0];

   a_r2_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit && !swr) |=> $stable(active_regs));

   a_r5_oe_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit && !swr) |=> $stable(out_enable));

   a_r3_commit_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> fall);

   a_r4_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_set && !swr) |=> !commit);

   a_r8_swrst_defaults: assert property (@(posedge clk) disable iff (!rst_n)
      swr |=> (active_regs == ALL_DFLT && !out_enable && !core_run));

   a_r6_run_rise_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_run) |-> ($past(commit) || $past(commit, 2)));
endmodule

bind sync_shadow_regbank ssrb_checker #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
   .REG_DEFAULT(REG_DEFAULT), .ADDR_SWRST(ADDR_SWRST), .ADDR_HOLD(ADDR_HOLD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .active_regs(active_regs), .out_enable(out_enable), .core_run(core_run),
   .fall(sync_fall), .commit(commit));

// File: tb/sync_shadow_regbank_test.sv
`timescale 1ns/1ps
module sync_shadow_regbank_test;
   localparam int DW = 8;
   localparam int AW = 8;
   localparam int NR = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic vd_in = 1'b1;
   logic hd_in = 1'b1;
   logic [NR*DW-1:0] active_regs;
   logic out_enable, core_run;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   sync_shadow_regbank #(.DATA_W(DW), .ADDR_W(AW), .NUM_REGS(NR)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .vd_in(vd_in), .hd_in(hd_in), .active_regs(active_regs),
      .out_enable(out_enable), .core_run(core_run));

   // {op[3:0], req[3:0], addr[7:0], data[7:0]}
   // op 0 write, 1 sync pulse, 2 check reg[addr]==data, 3 check out_enable, 4 check core_run
   localparam int NV = 30;
   localparam logic [23:0] VEC [NV] = '{
      24'h0203A5, 24'h220300, 24'h120000, 24'h2203A5,             // R2
      24'h0A0311, 24'h0A0322, 24'h1A0000, 24'h2A0322,             // R10 last wins
      24'h1A0000, 24'h2A0322,                                     // R10 no re-apply
      24'h051101, 24'h350000, 24'h150000, 24'h350001,             // R5
      24'h061201, 24'h160000, 24'h460000,                         // R6 1 alone
      24'h061200, 24'h160000, 24'h460000,                         // R6 low committed
      24'h061201, 24'h460000, 24'h160000, 24'h460001,             // R6 high committed
      24'h02007E, 24'h020F81, 24'h120000, 24'h22007E, 24'h220F81, // R2 ends
      24'h120000                                                  // R10 idle commit
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic pulse();
      @(negedge clk); vd_in = 1'b0;
      repeat (5) @(negedge clk);
      vd_in = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   function automatic logic [7:0] reg_at(input int i);
      return active_regs[i*DW +: DW];
   endfunction

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 regs", 32'(active_regs == '0), 32'd1);
      chk("R1 oe", 32'(out_enable), 32'd0);
      chk("R1 run", 32'(core_run), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int k = 0; k < NV; k++) begin
         logic [3:0] op, rq;
         logic [7:0] a, d;
         {op, rq, a, d} = VEC[k];
         case (op)
            4'd0: wr(a, d);
            4'd1: pulse();
            4'd2: chk($sformatf("R%0d reg%0d", rq, a), 32'(reg_at(int'(a))), 32'(d));
            4'd3: chk($sformatf("R%0d oe", rq), 32'(out_enable), 32'(d));
            default: chk($sformatf("R%0d run", rq), 32'(core_run), 32'(d));
         endcase
      end

      // R3 latency: third rising edge after the fall
      wr(8'h05, 8'h3C);
      @(negedge clk); vd_in = 1'b0;
      @(negedge clk);
      @(negedge clk); chk("R3 before 3rd edge", 32'(reg_at(5)), 32'h00);
      @(negedge clk); chk("R3 at 3rd edge", 32'(reg_at(5)), 32'h3C);
      repeat (3) @(negedge clk); vd_in = 1'b1;
      repeat (5) @(negedge clk);

      // R7 one-cycle restart while running
      wr(8'h12, 8'h00);
      wr(8'h12, 8'h01);
      @(negedge clk); vd_in = 1'b0;
      @(negedge clk);
      @(negedge clk); chk("R7 before commit", 32'(core_run), 32'd1);
      @(negedge clk); chk("R7 low at commit", 32'(core_run), 32'd0);
      @(negedge clk); chk("R7 back high", 32'(core_run), 32'd1);
      repeat (2) @(negedge clk); vd_in = 1'b1;
      repeat (5) @(negedge clk);

      // R4 hold
      wr(8'h14, 8'h01);
      wr(8'h07, 8'h5A);
      pulse();
      chk("R4 held", 32'(reg_at(7)), 32'h00);
      wr(8'h14, 8'h00);
      repeat (3) @(negedge clk);
      chk("R4 release alone", 32'(reg_at(7)), 32'h00);
      pulse();
      chk("R4 applied", 32'(reg_at(7)), 32'h5A);

      // R9 ignored addresses
      wr(8'h13, 8'hFF);
      wr(8'h15, 8'hFF);
      wr(8'h20, 8'hFF);
      wr(8'h10, 8'h00);
      chk("R9 reg3 now", 32'(reg_at(3)), 32'h22);
      pulse();
      chk("R9 reg3", 32'(reg_at(3)), 32'h22);
      chk("R9 reg7", 32'(reg_at(7)), 32'h5A);
      chk("R9 oe", 32'(out_enable), 32'd1);
      chk("R9 run", 32'(core_run), 32'd1);

      // R8 software reset
      wr(8'h09, 8'h44);
      wr(8'h14, 8'h01);
      wr(8'h10, 8'h01);
      chk("R8 regs", 32'(active_regs == '0), 32'd1);
      chk("R8 oe", 32'(out_enable), 32'd0);
      chk("R8 run", 32'(core_run), 32'd0);
      pulse();
      chk("R8 no stale", 32'(reg_at(9)), 32'h00);
      wr(8'h02, 8'h66);
      pulse();
      chk("R8 hold cleared", 32'(reg_at(2)), 32'h66);

      finish_run();
   end
endmodule